// File: doc/BRIEF.md
# Windowed Host Address Remapper

This block sits between a host-facing memory window and an on-chip memory bus. The host sees a 1 MB window, and each host access carries a 20-bit word-aligned offset into it. The device behind the window has a 32 MB internal address space, so the block translates every host offset into a 25-bit internal address. Offsets in the lower half of the window go straight through. Offsets in the upper half are redirected into one of 64 slices of 512 KB each. The slice is chosen by a window-select register, and that register is itself reached through the lower half of the window.

The host hands over one access at a time with a valid/ready pair. The block either services the access locally (the select register, or a blocked upper-half read) or launches a single-cycle request on the internal bus. For an internal read it waits for the memory's data and returns it to the host. Read responses come back in the same order as the accesses.

Top module: `bar_window_remap`

## Requirements
- R1: After reset the select register holds enable = 0 and window = 0, `hostReady` is 1, and `memReq` and `hostRvalid` are 0.
- R2: An access whose offset has bit 19 clear, and which is not the select register, issues a request with `memAddr` equal to the offset with bits 1:0 forced to zero and bits 24:20 zero.
- R3: While enable is set, an access whose offset has bit 19 set issues a request with `memAddr[24:19]` equal to the window value and `memAddr[18:0]` equal to offset bits 18:2 followed by two zero bits.
- R4: The word at offset 0x310C is the select register. A write there loads enable from `hostWdata[31]` and the window from `hostWdata[5:0]`. A read returns enable in bit 31 and the window in bits 5:0. Neither a read nor a write of it reaches the internal bus.
- R5: Writes to bits 30:6 of the select register have no effect, and those bits always read as zero.
- R6: While enable is clear, an upper-half write issues no request and an upper-half read returns 0xDEADBEEF without any request.
- R7: A write to the select register applies to the very next access, even when that access follows it back to back.
- R8: Offset bits 1:0 are ignored everywhere, including when the select register is addressed.
- R9: For an internal read, `hostReady` stays low from acceptance until the response. `hostRvalid` rises one cycle after `memRvalid`, with `hostRdata` equal to the `memRdata` sampled with it. Responses keep the order of the accesses.
- R10: A request appears on `memReq` for exactly the cycle after the access is accepted. A locally serviced read answers on `hostRvalid` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access present |
| hostReady | output | 1 | Block can accept an access this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostOffset | input | 20 | Byte offset into the host window |
| hostWdata | input | 32 | Host write data |
| hostRvalid | output | 1 | Read response valid (one cycle) |
| hostRdata | output | 32 | Read response data |
| memReq | output | 1 | Internal bus request strobe |
| memWrite | output | 1 | Internal request is a write |
| memAddr | output | 25 | Translated internal address |
| memWdata | output | 32 | Internal write data |
| memRvalid | input | 1 | Internal read data valid |
| memRdata | input | 32 | Internal read data |

## Verification
The bench builds the block with its default parameters: a 20-bit offset, a 25-bit internal address and 32-bit data, with the select register at 0x310C. These values give a 6-bit window. The bench sweeps window values, including 0 and 63, so translated addresses reach both ends of the 32 MB space. It also probes the first and last words of each half of the window. The memory model answers reads after a latency that varies from access to access, which exercises the stall on `hostReady` and the ordering of responses.

// File: rtl/bar_window_remap_pkg.sv
package bar_window_remap_pkg;

  // Classification of an incoming host offset
  typedef enum logic [1:0] {
    RGN_FIXED   = 2'd0,
    RGN_CTRL    = 2'd1,
    RGN_WINDOW  = 2'd2,
    RGN_BLOCKED = 2'd3
  } region_e;

  // Sequencer state
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

  // One-cycle strobes from the control to the datapath
  typedef struct packed {
    logic launch;       // issue an internal request next cycle
    logic launchWrite;  // that request is a write
    logic ctrlWrite;    // load the select register
    logic respCtrl;     // answer with the select register contents
    logic respBlocked;  // answer with the blocked-read pattern
    logic captureMem;   // answer with the internal read data
  } strobe_t;

endpackage

// File: rtl/bar_window_ctrl.sv
module bar_window_ctrl
  import bar_window_remap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostValid,
  input  logic    hostWrite,
  input  region_e region,
  input  logic    memRvalid,
  output logic    hostReady,
  output strobe_t strobe
);

  seq_state_e state, stateNext;
  logic accept;

  assign hostReady = (state == ST_IDLE);
  assign accept    = hostValid && hostReady;

  always_comb begin
    strobe             = '0;
    strobe.launch      = accept && (region == RGN_FIXED || region == RGN_WINDOW);
    strobe.launchWrite = strobe.launch && hostWrite;
    strobe.ctrlWrite   = accept && (region == RGN_CTRL) && hostWrite;
    strobe.respCtrl    = accept && (region == RGN_CTRL) && !hostWrite;
    strobe.respBlocked = accept && (region == RGN_BLOCKED) && !hostWrite;
    strobe.captureMem  = (state == ST_WAIT) && memRvalid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.launch && !hostWrite) stateNext = ST_WAIT;
      ST_WAIT: if (memRvalid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/bar_window_datapath.sv
module bar_window_datapath
  import bar_window_remap_pkg::*;
#(
  parameter int                   OFFSET_W    = 20,
  parameter int                   INT_ADDR_W  = 25,
  parameter int                   DATA_W      = 32,
  parameter logic [OFFSET_W-1:0]  CTRL_OFFSET = 20'h310C,
  parameter logic [DATA_W-1:0]    DEAD_WORD   = 32'hDEADBEEF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [OFFSET_W-1:0]   hostOffset,
  input  logic [DATA_W-1:0]     hostWdata,
  input  logic [DATA_W-1:0]     memRdata,
  output region_e               region,
  output logic                  hostRvalid,
  output logic [DATA_W-1:0]     hostRdata,
  output logic                  memReq,
  output logic                  memWrite,
  output logic [INT_ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic                  winEnable,
  output logic [INT_ADDR_W-OFFSET_W:0] winValue
);

  localparam int FIXED_W = OFFSET_W - 1;            // bits kept inside one slice
  localparam int WIN_W   = INT_ADDR_W - FIXED_W;    // slice-select width
  localparam int WORD_W  = OFFSET_W - 2;            // word index width
  localparam logic [WORD_W-1:0] CTRL_WORD = CTRL_OFFSET[OFFSET_W-1:2];

  logic                  upperHalf;
  logic [WORD_W-1:0]     wordIdx;
  logic [WIN_W-1:0]      addrPrefix;
  logic [INT_ADDR_W-1:0] transAddr;
  logic [DATA_W-1:0]     ctrlReadWord;
  logic                  unusedLowBits;

  assign unusedLowBits = ^hostOffset[1:0];
  assign upperHalf     = hostOffset[OFFSET_W-1];
  assign wordIdx       = hostOffset[OFFSET_W-1:2];

  // Region decode
  always_comb begin
    if (upperHalf)                region = winEnable ? RGN_WINDOW : RGN_BLOCKED;
    else if (wordIdx == CTRL_WORD) region = RGN_CTRL;
    else                          region = RGN_FIXED;
  end

  // Address translation: one prefix mux, low bits shared by both halves
  always_comb begin
    addrPrefix = upperHalf ? winValue : {WIN_W{1'b0}};
    transAddr  = {addrPrefix, hostOffset[FIXED_W-1:2], 2'b00};
  end

  // Select-register read image: enable in the top bit, window at the bottom
  for (genvar b = 0; b < DATA_W; b++) begin : g_readImage
    if (b == DATA_W - 1) begin : g_en
      assign ctrlReadWord[b] = winEnable;
    end else if (b < WIN_W) begin : g_win
      assign ctrlReadWord[b] = winValue[b];
    end else begin : g_zero
      assign ctrlReadWord[b] = 1'b0;
    end
  end

  // Select register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winEnable <= 1'b0;
      winValue  <= '0;
    end else if (strobe.ctrlWrite) begin
      winEnable <= hostWdata[DATA_W-1];
      winValue  <= hostWdata[WIN_W-1:0];
    end
  end

  // Internal bus request stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memWrite <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
    end else begin
      memReq <= strobe.launch;
      if (strobe.launch) begin
        memWrite <= strobe.launchWrite;
        memAddr  <= transAddr;
        memWdata <= hostWdata;
      end
    end
  end

  // Read response stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRvalid <= 1'b0;
      hostRdata  <= '0;
    end else begin
      hostRvalid <= strobe.respCtrl || strobe.respBlocked || strobe.captureMem;
      if (strobe.respCtrl)         hostRdata <= ctrlReadWord;
      else if (strobe.respBlocked) hostRdata <= DEAD_WORD;
      else if (strobe.captureMem)  hostRdata <= memRdata;
    end
  end

endmodule

// File: rtl/bar_window_remap.sv
module bar_window_remap
  import bar_window_remap_pkg::*;
#(
  parameter int                   OFFSET_W    = 20,
  parameter int                   INT_ADDR_W  = 25,
  parameter int                   DATA_W      = 32,
  parameter logic [OFFSET_W-1:0]  CTRL_OFFSET = 20'h310C,
  parameter logic [DATA_W-1:0]    DEAD_WORD   = 32'hDEADBEEF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostValid,
  output logic                  hostReady,
  input  logic                  hostWrite,
  input  logic [OFFSET_W-1:0]   hostOffset,
  input  logic [DATA_W-1:0]     hostWdata,
  output logic                  hostRvalid,
  output logic [DATA_W-1:0]     hostRdata,
  output logic                  memReq,
  output logic                  memWrite,
  output logic [INT_ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]     memWdata,
  input  logic                  memRvalid,
  input  logic [DATA_W-1:0]     memRdata
);

  localparam int WIN_W = INT_ADDR_W - OFFSET_W + 1;

  region_e          region;
  strobe_t          strobe;
  logic             winEnable;
  logic [WIN_W-1:0] winValue;

  bar_window_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostValid (hostValid),
    .hostWrite (hostWrite),
    .region    (region),
    .memRvalid (memRvalid),
    .hostReady (hostReady),
    .strobe    (strobe)
  );

  bar_window_datapath #(
    .OFFSET_W    (OFFSET_W),
    .INT_ADDR_W  (INT_ADDR_W),
    .DATA_W      (DATA_W),
    .CTRL_OFFSET (CTRL_OFFSET),
    .DEAD_WORD   (DEAD_WORD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostOffset (hostOffset),
    .hostWdata  (hostWdata),
    .memRdata   (memRdata),
    .region     (region),
    .hostRvalid (hostRvalid),
    .hostRdata  (hostRdata),
    .memReq     (memReq),
    .memWrite   (memWrite),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .winEnable  (winEnable),
    .winValue   (winValue)
  );

endmodule

// File: rtl/bar_window_remap_chk.sv
module bar_window_remap_chk #(
  parameter int                  OFFSET_W    = 20,
  parameter int                  INT_ADDR_W  = 25,
  parameter int                  DATA_W      = 32,
  parameter logic [OFFSET_W-1:0] CTRL_OFFSET = 20'h310C
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       hostValid,
  input logic                       hostReady,
  input logic                       hostWrite,
  input logic [OFFSET_W-1:0]        hostOffset,
  input logic                       hostRvalid,
  input logic [DATA_W-1:0]          hostRdata,
  input logic                       memReq,
  input logic                       memWrite,
  input logic [INT_ADDR_W-1:0]      memAddr,
  input logic                       memRvalid,
  input logic [DATA_W-1:0]          memRdata,
  input logic                       winEnable,
  input logic [INT_ADDR_W-OFFSET_W:0] winValue
);

  localparam int FIXED_W = OFFSET_W - 1;
  localparam logic [OFFSET_W-3:0] CTRL_WORD = CTRL_OFFSET[OFFSET_W-1:2];

  logic accept, ctrlHit;
  assign accept  = hostValid && hostReady;
  assign ctrlHit = !hostOffset[OFFSET_W-1] && (hostOffset[OFFSET_W-1:2] == CTRL_WORD);

  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> $past(accept)); // R10

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !hostOffset[OFFSET_W-1] && !ctrlHit) |=>
      (memReq && memAddr[INT_ADDR_W-1:FIXED_W] == '0 &&
       memAddr[FIXED_W-1:0] == {$past(hostOffset[FIXED_W-1:2]), 2'b00})); // R2

  AST_WINDOW_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && hostOffset[OFFSET_W-1] && winEnable) |=>
      (memReq && memAddr[INT_ADDR_W-1:FIXED_W] == $past(winValue))); // R3

  AST_BLOCKED_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (accept && hostOffset[OFFSET_W-1] && !winEnable) |=> !memReq); // R6

  AST_CTRL_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (accept && ctrlHit) |=> !memReq); // R4

  AST_STALL_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |-> !hostReady); // R9

  AST_RDATA_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (memRvalid && !hostReady) |=> (hostRvalid && hostRdata == $past(memRdata))); // R9

  AST_LOCAL_READ_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !hostWrite && (ctrlHit || (hostOffset[OFFSET_W-1] && !winEnable))) |=> hostRvalid); // R10

endmodule

bind bar_window_remap bar_window_remap_chk #(
  .OFFSET_W    (OFFSET_W),
  .INT_ADDR_W  (INT_ADDR_W),
  .DATA_W      (DATA_W),
  .CTRL_OFFSET (CTRL_OFFSET)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostValid  (hostValid),
  .hostReady  (hostReady),
  .hostWrite  (hostWrite),
  .hostOffset (hostOffset),
  .hostRvalid (hostRvalid),
  .hostRdata  (hostRdata),
  .memReq     (memReq),
  .memWrite   (memWrite),
  .memAddr    (memAddr),
  .memRvalid  (memRvalid),
  .memRdata   (memRdata),
  .winEnable  (winEnable),
  .winValue   (winValue)
);

// File: tb/bar_window_remap_bench.sv
module bar_window_remap_bench;

  localparam int OFFSET_W   = 20;
  localparam int INT_ADDR_W = 25;
  localparam int DATA_W     = 32;

  typedef struct {
    bit                    wr;
    logic [INT_ADDR_W-1:0] addr;
    logic [DATA_W-1:0]     data;
    string                 tag;
  } req_item_t;

  typedef struct {
    logic [DATA_W-1:0] data;
    string             tag;
  } resp_item_t;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  hostValid = 1'b0;
  logic                  hostReady;
  logic                  hostWrite = 1'b0;
  logic [OFFSET_W-1:0]   hostOffset = '0;
  logic [DATA_W-1:0]     hostWdata = '0;
  logic                  hostRvalid;
  logic [DATA_W-1:0]     hostRdata;
  logic                  memReq;
  logic                  memWrite;
  logic [INT_ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0]     memWdata;
  logic                  memRvalid = 1'b0;
  logic [DATA_W-1:0]     memRdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  req_item_t  reqQ[$];
  resp_item_t respQ[$];

  // requirement-level model of the select register
  bit       modelEn = 1'b0;
  bit [5:0] modelWin = '0;

  always #5 clk = ~clk;

  bar_window_remap u_bar_window_remap (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostReady(hostReady), .hostWrite(hostWrite),
    .hostOffset(hostOffset), .hostWdata(hostWdata),
    .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRdata(memRdata)
  );

  function automatic logic [DATA_W-1:0] memPattern(logic [INT_ADDR_W-1:0] a);
    return {7'b1010011, a};
  endfunction

  task automatic check(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      check(1'b0, "watchdog", 32'(cycles), 32'd100000);
      finishRun();
    end
  end

  // memory model: read data after a varying latency
  int latSeed = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memReq && !memWrite) begin
        logic [INT_ADDR_W-1:0] a;
        a = memAddr;
        latSeed++;
        repeat (latSeed % 3) @(negedge clk);
        memRdata  = memPattern(a);
        memRvalid = 1'b1;
        @(negedge clk);
        memRvalid = 1'b0;
        memRdata  = '0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq) begin
        if (reqQ.size() == 0) check(1'b0, "R6 unexpected request", 32'(memAddr), 32'h0);
        else begin
          req_item_t e;
          e = reqQ.pop_front();
          check(memAddr == e.addr && memWrite == e.wr, e.tag, 32'(memAddr), 32'(e.addr));
          if (e.wr) check(memWdata == e.data, e.tag, memWdata, e.data);
        end
      end
      if (hostRvalid) begin
        if (respQ.size() == 0) check(1'b0, "R9 unexpected response", hostRdata, 32'h0);
        else begin
          resp_item_t r;
          r = respQ.pop_front();
          check(hostRdata == r.data, r.tag, hostRdata, r.data);
        end
      end
    end
  end

  // driver: computes expectations from the requirements and issues one access
  task automatic access(bit wr, logic [OFFSET_W-1:0] off, logic [DATA_W-1:0] wd, string tag);
    logic [OFFSET_W-1:0] word;
    bit expReq, memRead, localRead;
    expReq = 0; memRead = 0; localRead = 0;
    word = {off[OFFSET_W-1:2], 2'b00};
    while (!hostReady) @(negedge clk);
    if (!word[19]) begin
      if (word == 20'h310C) begin
        if (wr) begin
          modelEn  = wd[31];
          modelWin = wd[5:0];
        end else begin
          respQ.push_back('{{modelEn, 25'b0, modelWin}, tag});
          localRead = 1;
        end
      end else begin
        reqQ.push_back('{wr, {5'b0, word}, wd, tag});
        expReq = 1;
        if (!wr) begin
          respQ.push_back('{memPattern({5'b0, word}), tag});
          memRead = 1;
        end
      end
    end else if (modelEn) begin
      reqQ.push_back('{wr, {modelWin, word[18:0]}, wd, tag});
      expReq = 1;
      if (!wr) begin
        respQ.push_back('{memPattern({modelWin, word[18:0]}), tag});
        memRead = 1;
      end
    end else if (!wr) begin
      respQ.push_back('{32'hDEADBEEF, tag});
      localRead = 1;
    end
    hostValid = 1'b1; hostWrite = wr; hostOffset = off; hostWdata = wd;
    @(negedge clk);
    hostValid = 1'b0;
    // R10: request strobe exactly in the cycle after acceptance
    check(memReq == expReq, "R10 request timing", 32'(memReq), 32'(expReq));
    if (localRead) check(hostRvalid == 1'b1, "R10 local answer timing", 32'(hostRvalid), 32'd1);
    if (memRead)   check(hostReady == 1'b0, "R9 stall while read pending", 32'(hostReady), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hostReady == 1'b1, "R1 ready after reset", 32'(hostReady), 32'd1);
    check(memReq == 1'b0, "R1 no request in reset", 32'(memReq), 32'd0);
    check(hostRvalid == 1'b0, "R1 no response in reset", 32'(hostRvalid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    access(0, 20'h0310C, '0, "R1 select register reset value");

    // R2: fixed half
    access(0, 20'h00000, '0, "R2 fixed bottom read");
    access(0, 20'h7FFFC, '0, "R2 fixed top read");
    access(1, 20'h40000, 32'h11223344, "R2 fixed write");
    access(0, 20'h12347, '0, "R8 low bits ignored fixed");

    // R6: upper half blocked after reset
    access(0, 20'h80000, '0, "R6 blocked read");
    access(1, 20'hFFFFC, 32'hCAFEF00D, "R6 blocked write");

    // R4/R5: select register write and readback
    access(1, 20'h0310C, 32'hFFFFFFFF, "R4 select write all ones");
    access(0, 20'h0310C, '0, "R5 unused bits read zero");
    // R8 on the select register, then R7 back-to-back use
    access(1, 20'h0310F, 32'h80000015, "R8 select via unaligned offset");
    access(0, 20'h80004, '0, "R7 next access uses new window");
    access(0, 20'h0310D, '0, "R4 select readback");

    // R3: window sweep including 0 and 63
    for (int w = 0; w < 64; w += 21) begin
      access(1, 20'h0310C, 32'h80000000 | 32'(w), "R4 select write");
      access(0, 20'hFFFFC, '0, "R3 window top read");
      access(1, 20'h80010, 32'(w) ^ 32'h5A5A0000, "R3 window write");
    end
    access(1, 20'h0310C, 32'h8000003F, "R4 select write");
    access(0, 20'h80000, '0, "R3 window 63 bottom");
    access(0, 20'h00100, '0, "R2 fixed unaffected by window");

    // R6: disable again, window value is kept
    access(1, 20'h0310C, 32'h0000003F, "R4 select disable");
    access(0, 20'hC0000, '0, "R6 blocked after disable");
    access(1, 20'hC0000, 32'h1, "R6 blocked write after disable");
    access(0, 20'h0310C, '0, "R5 readback after disable");

    repeat (8) @(negedge clk);
    check(reqQ.size() == 0, "R9 all requests seen", 32'(reqQ.size()), 32'd0);
    check(respQ.size() == 0, "R9 all responses seen", 32'(respQ.size()), 32'd0);
    done = 1'b1;
    finishRun();
  end

endmodule